// File: doc/BRIEF.md
# Framed Serial Transmitter

The block turns one parallel word into a serial bit stream with its own data clock and a leading framing marker. It runs entirely in one fast system clock domain. An internal divider produces an enable pulse every `HALF_DIV` fast cycles; each pulse marks one half of a data-clock period. The pulses alternate between a rising-point and a falling-point role, and the outgoing data clock, data line and marker all change only on those pulses.

A frame starts when `start` is sampled high while the block is idle. For one full data-clock period the marker `tag` is high and `dclk` is held low. Then the word is shifted out starting with bit 0. Each bit is placed on `sdata` at a falling point, so it has been stable for half a period when `dclk` rises in the middle of the bit. After the last bit `dclk` stays low, `sdata` returns to 0 and `busy` drops. Reset is synchronous and abandons any frame in progress.

Top module: `framed_serial_tx`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `dclk`, `sdata`, `tag` and `busy` are all 0.
- R2: `start` is accepted only when `busy` is 0. A `start` pulse while `busy` is 1 neither restarts the frame nor changes the word being sent.
- R3: After `start` is accepted, `tag` is 1 from the next cycle for exactly 2*`HALF_DIV` fast cycles, and `dclk` is 0 for that whole time.
- R4: During a frame, `dclk` is high for exactly `HALF_DIV` cycles and low for `HALF_DIV` cycles per period, and rises exactly `WIDTH` times.
- R5: No `dclk` pulse comes between the end of `tag` and the first bit. The first `dclk` rise comes exactly `HALF_DIV` cycles after `tag` falls.
- R6: Bit k of the frame is `word[k]` (bit 0 first), as captured when `start` was accepted. `sdata` changes only in cycles where `dclk` is 0. It is set when `tag` falls or when `dclk` falls, so it is stable for `HALF_DIV` cycles before each `dclk` rise.
- R7: `busy` is 1 for exactly (2*`WIDTH`+2)*`HALF_DIV` cycles per frame. In the cycle `busy` drops, `dclk` and `sdata` are 0. While idle, all outputs stay 0.
- R8: `tag` rises exactly once per accepted word and never during the data bits.
- R9: A synchronous reset in the middle of a frame clears all outputs in the next cycle. A later `start` then begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send `word`, taken only when idle |
| word | input | WIDTH | Parallel word, captured when `start` is accepted |
| dclk | output | 1 | Generated data clock, 50 % duty, registered |
| sdata | output | 1 | Serial data, bit 0 first, registered |
| tag | output | 1 | Frame marker, high for one data-clock period, registered |
| busy | output | 1 | High while a frame is in progress |

## Verification
The bench runs frames whose first or last bit is the only 1 (0x01, 0x80), a mixed pattern and all ones. A design that sends the bits in the wrong order, or drops the last bit, sends the wrong stream for these words. It keeps `start` high across whole frames to test restart at the earliest cycle. It pulses `start` with a different word in the middle of a frame: a design that reloads or restarts the frame would send the new word or a second marker. The gap from the end of the marker to the first clock rise is measured, which catches a stray pulse after the marker or data launched together with the rising edge. A reset in the middle of a frame catches state, such as the half-period phase, that reset does not clear and that would skew the next frame.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_TAG  = 2'd1,
      FR_DATA = 2'd2
   } fr_state_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tx_halfbeat.sv
module tx_halfbeat #(
   parameter int HALF_DIV = 125
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic beat,
   output logic fall_pt
);
   logic ph_q;

   generate
      if (HALF_DIV == 1) begin : g_every_cycle
         assign beat = 1'b1;
      end else begin : g_counter
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || restart) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign beat = (cnt_q == LAST);

         // R4
         beat_gap_chk: assert property (@(posedge clk) disable iff (rst)
            beat |=> !beat);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         ph_q <= 1'b0;
      end else if (beat) begin
         ph_q <= ~ph_q;
      end
   end

   assign fall_pt = beat & ph_q;
endmodule

// File: rtl/tx_bit_pick.sv
module tx_bit_pick #(
   parameter int WIDTH = 16,
   parameter int IW    = 4
) (
   input  logic [WIDTH-1:0] word,
   input  logic [IW-1:0]    idx,
   output logic             bit_o
);
   always_comb begin
      bit_o = 1'b0;
      for (int i = 0; i < WIDTH; i++) begin
         if (idx == IW'(i)) bit_o = word[i];
      end
   end
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
   import tx_frame_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int HALF_DIV = 125
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] word,
   input  logic             beat,
   input  logic             fall_pt,
   output logic             restart,
   output logic             dclk,
   output logic             sdata,
   output logic             tag,
   output logic             busy
);
   localparam int IW = idx_bits(WIDTH);
   localparam logic [IW-1:0] LAST_IDX = IW'(WIDTH - 1);

   fr_state_e        state_q;
   logic [WIDTH-1:0] word_q;
   logic [IW-1:0]    idx_q;
   logic [IW-1:0]    idx_nxt;
   logic             nxt_bit;
   logic             rise_pt;

   assign rise_pt = beat & ~fall_pt;
   assign restart = (state_q == FR_IDLE) & start;
   assign busy    = (state_q != FR_IDLE);
   assign idx_nxt = (state_q == FR_TAG) ? '0 : idx_q + 1'b1;

   tx_bit_pick #(.WIDTH(WIDTH), .IW(IW)) u_pick (
      .word  (word_q),
      .idx   (idx_nxt),
      .bit_o (nxt_bit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FR_IDLE;
         word_q  <= '0;
         idx_q   <= '0;
         dclk    <= 1'b0;
         sdata   <= 1'b0;
         tag     <= 1'b0;
      end else begin
         case (state_q)
            FR_IDLE: begin
               if (start) begin
                  word_q  <= word;
                  tag     <= 1'b1;
                  state_q <= FR_TAG;
               end
            end
            FR_TAG: begin
               if (fall_pt) begin
                  tag     <= 1'b0;
                  sdata   <= nxt_bit;
                  idx_q   <= '0;
                  state_q <= FR_DATA;
               end
            end
            FR_DATA: begin
               if (rise_pt) begin
                  dclk <= 1'b1;
               end else if (fall_pt) begin
                  dclk <= 1'b0;
                  if (idx_q == LAST_IDX) begin
                     sdata   <= 1'b0;
                     state_q <= FR_IDLE;
                  end else begin
                     idx_q <= idx_nxt;
                     sdata <= nxt_bit;
                  end
               end
            end
            default: state_q <= FR_IDLE;
         endcase
      end
   end

   int tag_len_q;
   int hi_len_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_len_q <= 0;
         hi_len_q  <= 0;
      end else begin
         tag_len_q <= tag  ? tag_len_q + 1 : 0;
         hi_len_q  <= dclk ? hi_len_q + 1 : 0;
      end
   end

   // R3
   tag_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(tag) |-> tag_len_q == 2 * HALF_DIV);

   // R4
   dclk_high_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dclk) |-> hi_len_q == HALF_DIV);

   // R2
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q != FR_IDLE) |=> $stable(word_q));

   // R8
   tag_once_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == FR_DATA) |-> !tag);
endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx #(
   parameter int WIDTH    = 16,
   parameter int HALF_DIV = 125
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] word,
   output logic             dclk,
   output logic             sdata,
   output logic             tag,
   output logic             busy
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("framed_serial_tx: WIDTH must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("framed_serial_tx: HALF_DIV must be at least 1");
      end
   endgenerate

   logic beat;
   logic fall_pt;
   logic restart;

   tx_halfbeat #(.HALF_DIV(HALF_DIV)) u_beat (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .beat    (beat),
      .fall_pt (fall_pt)
   );

   tx_frame_fsm #(.WIDTH(WIDTH), .HALF_DIV(HALF_DIV)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .word    (word),
      .beat    (beat),
      .fall_pt (fall_pt),
      .restart (restart),
      .dclk    (dclk),
      .sdata   (sdata),
      .tag     (tag),
      .busy    (busy)
   );

   // R3
   tag_dclk_low_chk: assert property (@(posedge clk) disable iff (rst)
      tag |-> !dclk);

   // R6
   data_setup_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(dclk) |-> $stable(sdata));

   // R6
   data_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(sdata) |-> !dclk);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!dclk && !tag && !sdata));

   // R5
   no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(dclk) |-> (busy && !tag && !$past(tag)));
endmodule

// File: tb/tb_framed_serial_tx.sv
`timescale 1ns/1ps
module tb_framed_serial_tx;
   localparam int H = 3;
   localparam int W = 8;
   localparam int FRAME = (2 * W + 2) * H;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] word = '0;
   logic         dclk, sdata, tag, busy;

   always #2 clk = ~clk;

   framed_serial_tx #(.WIDTH(W), .HALF_DIV(H)) dut (
      .clk(clk), .rst(rst), .start(start), .word(word),
      .dclk(dclk), .sdata(sdata), .tag(tag), .busy(busy)
   );

   int total = 0;
   int bad   = 0;
   bit mon_on = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // behavioural reference: cycles since acceptance
   bit           m_busy = 0;
   bit           m_rst  = 1;
   int           m_t    = 0;
   int           m_accepts = 0;
   logic [W-1:0] m_word = '0;

   always @(posedge clk) begin
      m_rst = rst;
      if (rst) begin
         m_busy = 0;
      end else if (!m_busy) begin
         if (start) begin
            m_busy = 1;
            m_t    = 0;
            m_word = word;
            m_accepts++;
         end
      end else begin
         m_t++;
         if (m_t == FRAME) m_busy = 0;
      end
   end

   bit p_d = 0, p_t = 0, p_b = 0;
   int tag_len = 0, hi_len = 0, gap = 0, rises = 0, tag_rises = 0;
   int tag_total = 0, busy_len = 0;
   bit gap_on = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         int hh, k;
         bit e_t, e_d, e_s, e_b;
         e_t = 0; e_d = 0; e_s = 0; e_b = 0;
         if (m_busy) begin
            hh  = m_t / H;
            e_b = 1;
            if (hh < 2) begin
               e_t = 1;
            end else begin
               k   = (hh - 2) / 2;
               e_d = ((hh - 2) % 2) == 1;
               e_s = m_word[k];
            end
         end
         chk(tag   === e_t, "R3", "tag",   int'(tag),   int'(e_t));
         chk(dclk  === e_d, "R4", "dclk",  int'(dclk),  int'(e_d));
         chk(sdata === e_s, "R6", "sdata", int'(sdata), int'(e_s));
         chk(busy  === e_b, "R7", "busy",  int'(busy),  int'(e_b));

         if (m_rst) begin
            p_d = 0; p_t = 0; p_b = 0;
            tag_len = 0; hi_len = 0; gap = 0; rises = 0; tag_rises = 0;
            busy_len = 0; gap_on = 0;
         end else begin
            if (tag && !p_t) begin
               tag_rises++;
               tag_total++;
               tag_len = 0;
            end
            if (tag) tag_len++;
            if (!tag && p_t) begin
               chk(tag_len == 2 * H, "R3", "tag length", tag_len, 2 * H);
               gap = 0;
               gap_on = 1;
            end
            if (gap_on && !dclk) gap++;
            if (dclk && !p_d) begin
               if (gap_on) begin
                  chk(gap == H, "R5", "tag-to-first-rise gap", gap, H);
                  gap_on = 0;
               end
               rises++;
               hi_len = 0;
            end
            if (dclk) hi_len++;
            if (!dclk && p_d) chk(hi_len == H, "R4", "dclk high length", hi_len, H);
            if (busy) busy_len++;
            if (!busy && p_b) begin
               chk(rises == W, "R4", "dclk rises per frame", rises, W);
               chk(tag_rises == 1, "R8", "tag rises per frame", tag_rises, 1);
               chk(busy_len == FRAME, "R7", "busy length", busy_len, FRAME);
               rises = 0; tag_rises = 0; busy_len = 0;
            end
            p_d = dclk; p_t = tag; p_b = busy;
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
         finish_up();
      end
   end

   task automatic send(input logic [W-1:0] w);
      @(negedge clk);
      start = 1'b1;
      word  = w;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(dclk == 0 && sdata == 0 && tag == 0 && busy == 0, "R1", "outputs in reset",
          int'({dclk, sdata, tag, busy}), 0);
      rst = 1'b0;
      mon_on = 1;
      @(negedge clk);
      chk({dclk, sdata, tag, busy} == 4'b0, "R1", "outputs after reset",
          int'({dclk, sdata, tag, busy}), 0);

      // R6: bit order with mixed, lowest-only and highest-only words
      send(8'hA5); wait_idle();
      send(8'h01); wait_idle();
      send(8'h80); wait_idle();

      // R2: start with a new word while busy is ignored
      send(8'hFF);
      repeat (10) @(negedge clk);
      start = 1'b1; word = 8'h3C;
      @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R2: start held high, restart at the earliest idle cycle
      @(negedge clk);
      start = 1'b1; word = 8'h5A;
      repeat (3 * FRAME) @(negedge clk);
      start = 1'b0;
      wait_idle();

      // R9: reset in the middle of a frame
      send(8'hC3);
      repeat (30) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk({dclk, sdata, tag, busy} == 4'b0, "R9", "outputs after mid-frame reset",
          int'({dclk, sdata, tag, busy}), 0);
      rst = 1'b0;
      @(negedge clk);
      send(8'h96); wait_idle();

      // R8: one tag per accepted word overall
      chk(tag_total == m_accepts, "R8", "tag count vs accepted words", tag_total, m_accepts);
      // R7: quiet while idle
      repeat (5) @(negedge clk);
      chk({dclk, sdata, tag, busy} == 4'b0, "R7", "idle outputs",
          int'({dclk, sdata, tag, busy}), 0);
      finish_up();
   end
endmodule